// File: doc/BRIEF.md
# Full-Adder Tree Population Counter

This block reports how many bits of an input word are set. It has no clock and no storage. The count appears on the output as soon as the input settles. The logic is a compressor tree made only of one-bit full-adder cells. Each cell takes three bits of equal weight and produces a sum bit of that weight and a carry bit of twice that weight. The block never uses an inferred multi-bit adder.

With its default width of seven, the block uses four cells. Two cells each reduce a group of three input bits to a two-bit partial count. A two-cell ripple stage then adds those partial counts, and the seventh bit enters that stage as its carry-in. With a width of eight, the block uses eight cells. Three first-level cells handle three groups, and the last group is padded with a zero. A two-cell ripple stage adds the first two partial counts. A three-cell ripple stage then adds the third partial count and widens the result to four bits.

Top module: `popTreeCounter`

## Requirements
- R1: With DATA_W = 7, the 3-bit output `onesCount` equals the number of set bits of `dataIn`, for every one of the 128 input values.
- R2: With DATA_W = 8, the 4-bit output `onesCount` equals the number of set bits of `dataIn`, for every one of the 256 input values, including the count of 8.
- R3: The output never exceeds DATA_W.
- R4: Bit 0 of `onesCount` always equals the XOR of all bits of `dataIn`.
- R5: `onesCount` is 0 exactly when `dataIn` is all zeros.
- R6: `onesCount` equals DATA_W exactly when every bit of `dataIn` is 1.
- R7: A word with a single set bit gives a count of 1, whichever bit position is set. This includes the top bit, which enters the tree at a different level from the other bits.
- R8: The output is purely combinational. It follows a change of `dataIn` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | DATA_W | Word whose set bits are counted |
| onesCount | output | $clog2(DATA_W+1) | Binary count of the set bits |

## Verification
The assertions assume that `dataIn` carries known two-state values. They also assume that DATA_W is either 7 or 8, the only two tree shapes the block builds. The parity, zero, all-ones and range checks are evaluated each time the input changes. The bench drives only fully defined words and instantiates the block once at each supported width. It sweeps every value those widths allow, so the stimulus never leaves the assumed domain.

// File: rtl/popc_pkg.sv
package popc_pkg;
  // Bits needed to hold a count from 0 to n inclusive.
  function automatic int countWidth(int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/popFullAdder.sv
module popFullAdder (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ c;
    co = (a & b) | (a & c) | (b & c);
  end
endmodule

// File: rtl/popGroupStage.sv
// First tree level: one full-adder cell per group of three equal-weight bits.
module popGroupStage #(
  parameter int GROUPS = 2
) (
  input  logic [3*GROUPS-1:0] triples,
  output logic [GROUPS-1:0]   sumBits,
  output logic [GROUPS-1:0]   carryBits
);
  for (genvar g = 0; g < GROUPS; g++) begin : g_cell
    popFullAdder u_fa (
      .a (triples[3*g]),
      .b (triples[3*g+1]),
      .c (triples[3*g+2]),
      .s (sumBits[g]),
      .co(carryBits[g])
    );
  end
endmodule

// File: rtl/popRippleAdder.sv
// Ripple adder built only from full-adder cells.
module popRippleAdder #(
  parameter int W = 2
) (
  input  logic [W-1:0] addA,
  input  logic [W-1:0] addB,
  input  logic         carryIn,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);
  logic [W:0] chain;
  assign chain[0] = carryIn;
  for (genvar i = 0; i < W; i++) begin : g_bit
    popFullAdder u_fa (
      .a (addA[i]),
      .b (addB[i]),
      .c (chain[i]),
      .s (sumOut[i]),
      .co(chain[i+1])
    );
  end
  assign carryOut = chain[W];
endmodule

// File: rtl/popTreeCounter.sv
module popTreeCounter #(
  parameter int DATA_W = 7,
  localparam int CNT_W = popc_pkg::countWidth(DATA_W)
) (
  input  logic [DATA_W-1:0] dataIn,
  output logic [CNT_W-1:0]  onesCount
);
  if (DATA_W == 7) begin : g_seven
    logic [1:0] grpSum;
    logic [1:0] grpCarry;
    popGroupStage #(.GROUPS(2)) u_level1 (
      .triples  (dataIn[5:0]),
      .sumBits  (grpSum),
      .carryBits(grpCarry)
    );
    // The seventh bit has weight 1, so it enters as the carry-in.
    popRippleAdder #(.W(2)) u_merge (
      .addA    ({grpCarry[0], grpSum[0]}),
      .addB    ({grpCarry[1], grpSum[1]}),
      .carryIn (dataIn[6]),
      .sumOut  (onesCount[1:0]),
      .carryOut(onesCount[2])
    );
  end else begin : g_eight
    logic [2:0] grpSum;
    logic [2:0] grpCarry;
    logic [2:0] partial;
    popGroupStage #(.GROUPS(3)) u_level1 (
      .triples  ({1'b0, dataIn[7:0]}),
      .sumBits  (grpSum),
      .carryBits(grpCarry)
    );
    popRippleAdder #(.W(2)) u_mergeLow (
      .addA    ({grpCarry[0], grpSum[0]}),
      .addB    ({grpCarry[1], grpSum[1]}),
      .carryIn (1'b0),
      .sumOut  (partial[1:0]),
      .carryOut(partial[2])
    );
    popRippleAdder #(.W(3)) u_mergeHigh (
      .addA    (partial),
      .addB    ({1'b0, grpCarry[2], grpSum[2]}),
      .carryIn (1'b0),
      .sumOut  (onesCount[2:0]),
      .carryOut(onesCount[3])
    );
  end

  // Output-side invariants checked against the input word.
  always_comb begin
    a_r3_in_range: assert (onesCount <= CNT_W'(DATA_W));
    a_r4_parity:   assert (onesCount[0] == (^dataIn));
    a_r5_zero:     assert ((onesCount == '0) == (dataIn == '0));
    a_r6_full:     assert ((onesCount == CNT_W'(DATA_W)) == (&dataIn));
  end
endmodule

// File: tb/popTreeCounter_test.sv
module popTreeCounter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [6:0] dataNarrow;
  logic [2:0] cntNarrow;
  logic [7:0] dataWide;
  logic [3:0] cntWide;

  popTreeCounter #(.DATA_W(7)) uut     (.dataIn(dataNarrow), .onesCount(cntNarrow));
  popTreeCounter #(.DATA_W(8)) uutWide (.dataIn(dataWide),   .onesCount(cntWide));

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 1'b0;

  localparam int NVEC = 8;
  localparam logic [7:0] VEC_IN  [NVEC] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'hA5, 8'h5A, 8'hC3, 8'h40};
  localparam int         VEC_EXP [NVEC] = '{0, 8, 1, 7, 4, 4, 4, 1};

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int refCount(input logic [7:0] v, input int w);
    int n = 0;
    for (int i = 0; i < w; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      finish();
    end
  end

  initial begin
    dataNarrow = '0;
    dataWide   = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: the reset-time all-zero input gives a zero count
    check("R5 zero narrow", int'(cntNarrow), 0);
    check("R5 zero wide", int'(cntWide), 0);

    // Table-driven patterns
    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      dataWide   = VEC_IN[k];
      dataNarrow = VEC_IN[k][6:0];
      #2;
      check("R2 table wide", int'(cntWide), VEC_EXP[k]);
      check("R1 table narrow", int'(cntNarrow), refCount(VEC_IN[k], 7));
    end

    // R1, R3, R4: full sweep of the narrow block
    for (int v = 0; v < 128; v++) begin
      @(negedge clk);
      dataNarrow = 7'(v);
      #2;
      check("R1 sweep", int'(cntNarrow), refCount(8'(v), 7));
      check("R4 parity narrow", int'(cntNarrow[0]), refCount(8'(v), 7) % 2);
      if (cntNarrow > 3'd7) check("R3 range narrow", int'(cntNarrow), 7);
    end

    // R2, R3, R4: full sweep of the wide block
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      dataWide = 8'(v);
      #2;
      check("R2 sweep", int'(cntWide), refCount(8'(v), 8));
      check("R4 parity wide", int'(cntWide[0]), refCount(8'(v), 8) % 2);
      check("R3 range wide", int'(cntWide <= 4'd8), 1);
    end

    // R6: all ones gives the maximum count
    @(negedge clk);
    dataNarrow = 7'h7F;
    dataWide   = 8'hFF;
    #2;
    check("R6 full narrow", int'(cntNarrow), 7);
    check("R6 full wide", int'(cntWide), 8);

    // R7: one set bit at each position
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      dataWide = 8'(1) << p;
      if (p < 7) dataNarrow = 7'(1) << p;
      #2;
      check("R7 onehot wide", int'(cntWide), 1);
      if (p < 7) check("R7 onehot narrow", int'(cntNarrow), 1);
    end

    // R8: the output follows the input with no clock edge in between
    @(posedge clk);
    #1;
    dataNarrow = 7'h15;
    dataWide   = 8'hF0;
    #1;
    check("R8 comb narrow", int'(cntNarrow), 3);
    check("R8 comb wide", int'(cntWide), 4);
    dataNarrow = 7'h00;
    #1;
    check("R8 comb narrow back", int'(cntNarrow), 0);

    @(negedge clk);
    finish();
  end
endmodule